// File: doc/BRIEF.md
# Profile-Selected NCO Tuning Core

This block is the phase-generation stage of a direct digital synthesizer. A bank of byte-wide registers holds one 32-bit frequency tuning word for each of several profiles. A simple write strobe, address and data bus loads the bank one byte at a time. A profile-select input chooses which stored word feeds a 32-bit phase accumulator. The accumulator then advances by that word on every clock, so the output frequency is word × f_clk / 2^32.

Only the lower half of the accumulator modulus is a legal step. Any assembled word whose top bit is set is replaced by the largest legal value before the accumulator uses it. This keeps the synthesized tone below half the clock rate. The upper bits of the accumulator are passed on as the phase word for a downstream sine table. The full accumulator is also brought out so that the phase can be observed exactly.

Top module: `nco_profile_core`

## Requirements
- R1: On each rising clock edge outside reset, the 32-bit accumulator adds the effective word of the selected profile and wraps modulo 2^32.
- R2: Profile p (0..3) keeps its word in the four byte addresses 0x04+4p through 0x07+4p. The lowest address holds bits 7:0 and the highest holds bits 31:24, so profile 1 spans 0x08 (LSB) to 0x0B (MSB).
- R3: If bit 31 of the assembled word is 1, the accumulator steps by 0x7FFFFFFF instead. The step is therefore always below 2^31.
- R4: A byte written on a clock edge is part of the step taken on the following edge, and never part of the step taken on the write edge itself.
- R5: A change of `prof_sel` is used by the next rising edge. The accumulator phase carries on from its current value and is not reset.
- R6: While `rst` is high at a rising edge, the accumulator and every tuning byte are cleared to zero.
- R7: A write with `wr_en` low, or to an address outside 0x04..0x13, changes no tuning byte.
- R8: `phase_out` always equals bits 31:16 of the accumulator.
- R9: Starting from zero with profile word 0x556AAAAB selected, the accumulator holds N × 0x556AAAAB mod 2^32 after N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 6 | Byte address of the write |
| wr_data | input | 8 | Byte to store |
| prof_sel | input | 2 | Profile driving the accumulator |
| acc_out | output | 32 | Full phase accumulator |
| phase_out | output | 16 | Truncated phase for the sine lookup |

## Verification
The hardest case to reach is a word that is half-written. In that state the bank holds a mix of old and new bytes while the accumulator is already running on it. The clamp may engage or release on a single byte write. The stimulus therefore writes the bytes of the active profile one per cycle while that profile stays selected, and it loads a most significant byte with its top bit set. The reference model then has to track each intermediate step. Profile switches and a reset are also applied in the middle of a run, so that phase continuity and the clearing of the bank are both observed through the accumulator.

// File: rtl/nco_profile_core.sv
module nco_profile_core #(
  parameter int PROFILES  = 4,
  parameter int ACC_W     = 32,
  parameter int PHASE_W   = 16,
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic [$clog2(PROFILES)-1:0] prof_sel,
  output logic [ACC_W-1:0]            acc_out,
  output logic [PHASE_W-1:0]          phase_out
);
  localparam int BPW   = ACC_W / 8;
  localparam int NB    = PROFILES * BPW;
  localparam int IDX_W = $clog2(NB);
  localparam logic [ACC_W-1:0] LIMIT = {1'b0, {(ACC_W-1){1'b1}}};

  logic [7:0]                       bank [NB];
  logic [PROFILES-1:0][ACC_W-1:0]   words;
  logic [ADDR_W-1:0]                offs;
  logic                             hit;
  logic [ACC_W-1:0]                 raw, step, acc;

  assign offs = wr_addr - ADDR_W'(BASE_ADDR);
  assign hit  = (wr_addr >= ADDR_W'(BASE_ADDR)) && (offs < ADDR_W'(NB));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) bank[i] <= '0;
    end else if (wr_en && hit) begin
      bank[offs[IDX_W-1:0]] <= wr_data;
    end
  end

  for (genvar p = 0; p < PROFILES; p++) begin : g_prof
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      assign words[p][8*b +: 8] = bank[p*BPW + b];
    end
  end

  assign raw  = words[prof_sel];
  assign step = raw[ACC_W-1] ? LIMIT : raw;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end

  assign acc_out   = acc;
  assign phase_out = acc[ACC_W-1 -: PHASE_W];

  assert_reset_clears_R6: assert property (@(posedge clk)
    $past(rst) |-> (acc_out == '0 && words == '0));

  assert_step_legal_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((acc_out - $past(acc_out)) <= LIMIT));

  assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(hit))) |-> $stable(words));

  assert_phase_upper_R8: assert property (@(posedge clk) disable iff (rst)
    phase_out == acc_out[ACC_W-1 -: PHASE_W]);
endmodule

// File: tb/sim_nco_profile_core.sv
module sim_nco_profile_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  prof_sel = '0;
  logic [31:0] acc_out;
  logic [15:0] phase_out;

  int tests = 0, fails = 0;
  logic [7:0]  mbank [16];
  logic [31:0] macc = '0;
  logic [31:0] expq [$];
  string       tagq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_profile_core u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prof_sel(prof_sel), .acc_out(acc_out), .phase_out(phase_out));

  function automatic logic [31:0] eff(input int p);
    logic [31:0] w;
    w = {mbank[4*p+3], mbank[4*p+2], mbank[4*p+1], mbank[4*p]};
    return w[31] ? 32'h7FFF_FFFF : w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic we, input logic [5:0] a,
                     input logic [7:0] d, input logic [1:0] s, input string tag);
    logic [31:0] e;
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = a; wr_data = d; prof_sel = s;
    if (r) begin
      e = '0;
      for (int i = 0; i < 16; i++) mbank[i] = '0;
    end else begin
      e = macc + eff(int'(s));
      if (we && a >= 6'h04 && a <= 6'h13) mbank[a - 6'h04] = d;
    end
    macc = e;
    expq.push_back(e);
    tagq.push_back(tag);
    @(posedge clk);
  endtask

  task automatic put_word(input int p, input logic [31:0] w, input logic [1:0] s, input string tag);
    for (int b = 0; b < 4; b++)
      cyc(1'b0, 1'b1, 6'(4 + 4*p + b), w[8*b +: 8], s, tag);
  endtask

  task automatic run(input int n, input logic [1:0] s, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 6'h00, 8'h00, s, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({t, " acc"}, acc_out, e);
        check("R8 phase", {16'h0, phase_out}, {16'h0, e[31:16]});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mbank[i] = '0;
    cyc(1'b1, 1'b0, 6'h00, 8'h00, 2'd0, "R6 reset");
    cyc(1'b1, 1'b0, 6'h00, 8'h00, 2'd0, "R6 reset");
    put_word(1, 32'h556A_AAAB, 2'd0, "R2 load p1");
    run(100, 2'd1, "R9 run");
    #2;
    check("R9 N=100", acc_out, 32'(64'd100 * 64'h556A_AAAB));
    put_word(1, 32'h1234_5678, 2'd1, "R4 partial live");
    put_word(2, 32'hF000_0001, 2'd2, "R3 clamp live");
    run(5, 2'd2, "R3 clamp");
    put_word(0, 32'h8000_0000, 2'd0, "R3 edge");
    run(4, 2'd0, "R3 edge run");
    put_word(3, 32'h7FFF_FFFF, 2'd1, "R2 p3");
    run(6, 2'd3, "R1 wrap");
    cyc(1'b0, 1'b1, 6'h03, 8'hFF, 2'd1, "R7 below");
    cyc(1'b0, 1'b1, 6'h14, 8'hFF, 2'd1, "R7 above");
    cyc(1'b0, 1'b0, 6'h08, 8'hFF, 2'd1, "R7 no strobe");
    run(3, 2'd1, "R7 after");
    for (int k = 0; k < 8; k++) cyc(1'b0, 1'b0, 6'h00, 8'h00, 2'(k % 4), "R5 switch");
    cyc(1'b1, 1'b0, 6'h00, 8'h00, 2'd3, "R6 mid reset");
    for (int p = 0; p < 4; p++) run(2, 2'(p), "R6 bank clear");
    put_word(2, 32'h0000_0100, 2'd2, "R4 byte timing");
    run(3, 2'd2, "R4 run");
    run(2, 2'd0, "drain");
    #2;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule